// File: doc/BRIEF.md
# Serial Receiver with Deferred Error Flags

This block receives asynchronous serial characters. A one-cycle enable, `os_tick`, pulses sixteen times per bit period, and the block samples the line on it. A falling edge starts a frame. The start bit is checked again at its middle, and each later bit is sampled at its own centre. The assembled character goes into a two-entry holding buffer. The oldest entry is offered on a valid/ready stream. A byte leaves the buffer on any cycle where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high and `rx_ready` is low, the head byte stays put. New frames then fill the second entry. A frame that completes while both entries are full is dropped.

A byte whose stop bit is wrong or whose parity does not match is still kept. It carries its error tags through the buffer. The matching sticky flag rises only when that byte becomes the head, which is the same edge on which its data appears on `rx_data`. A third sticky flag records dropped frames. Writing a one to a flag's clear pulse resets it. The interrupt request combines each flag with its own enable.

Top module: `uart_err_rx`

## Requirements
- R1: A frame is a low start bit, then 7 data bits (`cfg_len8`=0) or 8 data bits (`cfg_len8`=1) sent least significant bit first, an optional parity bit, and one or two stop bits (`cfg_stop2`). Each bit is sampled at its centre. A 7-bit character is delivered with `rx_data[7]`=0.
- R2: A low level on the line that lasts less than half a bit period starts no frame and stores no byte.
- R3: When `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the data bits plus the parity bit must contain an even number of ones; with `cfg_par_odd`=1 an odd number. A mismatch is a parity error.
- R4: A stop bit sampled low is a framing error. When two stop bits are set, a low sample on either of them counts.
- R5: A byte with a framing or parity error is stored and delivered like any other byte.
- R6: If the buffer is empty when an erroneous byte is stored, `fe_flag`/`pe_flag` rise on the same clock edge on which `rx_valid` rises with that byte.
- R7: If an erroneous byte enters behind a waiting byte, its flag stays low until the waiting byte is taken. The flag then rises on the same edge on which the erroneous byte appears on `rx_data`.
- R8: If a frame completes while both entries are full and no byte is taken on that cycle, `oe_flag` is set and the new byte is discarded.
- R9: Each flag stays set until a cycle with its clear input at 1. Taking the erroneous byte does not clear the flag. If a set and a clear happen on the same cycle, the set wins.
- R10: `irq` is high when any flag is high together with its enable input.
- R11: A byte is taken on a cycle with `rx_valid` and `rx_ready` both high. While `rx_valid` is high and `rx_ready` is low, `rx_data` holds its value. Bytes come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop2 | input | 1 | Two stop bits |
| rx_data | output | 8 | Head byte of the buffer |
| rx_valid | output | 1 | Head byte present |
| rx_ready | input | 1 | Consumer takes the head byte |
| fe_flag | output | 1 | Sticky framing-error flag |
| pe_flag | output | 1 | Sticky parity-error flag |
| oe_flag | output | 1 | Sticky overrun flag |
| clr_fe | input | 1 | Write-one clear of `fe_flag` |
| clr_pe | input | 1 | Write-one clear of `pe_flag` |
| clr_oe | input | 1 | Write-one clear of `oe_flag` |
| ie_fe | input | 1 | Interrupt enable for framing errors |
| ie_pe | input | 1 | Interrupt enable for parity errors |
| ie_oe | input | 1 | Interrupt enable for overruns |
| irq | output | 1 | Interrupt request |

## Verification
A vector table sends frames that cover both character lengths, parity off, even and odd parity, one and two stop bits, and a spoiled parity or stop bit. These vectors show whether each setting changes the sampled data or only the error tag. Directed cases then:
- queue a good byte ahead of a bad one, to separate flag timing set at store time from timing set at head time;
- send three frames with no reads, to show which frame the overrun drops;
- apply a short low pulse, to tell a glitch from a start bit.

// File: rtl/uart_err_rx_pkg.sv
package uart_err_rx_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              fe;
    logic              pe;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_err_rx_sync.sv
module uart_err_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/uart_err_rx_frame.sv
module uart_err_rx_frame
  import uart_err_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      line,
  input  logic      len8,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      stop2,
  output logic      done,
  output rx_entry_t frame
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(BYTE_W);
  localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);
  localparam logic [IW-1:0] LAST_8 = IW'(BYTE_W - 1);
  localparam logic [IW-1:0] LAST_7 = IW'(BYTE_W - 2);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [BYTE_W-1:0] shreg;
  logic              par_bit;
  logic              stop_bad;
  logic              second_stop;
  logic [IW-1:0]     last_idx;

  assign last_idx = len8 ? LAST_8 : LAST_7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      idx         <= '0;
      shreg       <= '0;
      par_bit     <= 1'b0;
      stop_bad    <= 1'b0;
      second_stop <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          S_IDLE: begin
            if (!line) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == CNT_HALF) begin
              cnt <= '0;
              if (!line) begin
                st          <= S_DATA;
                shreg       <= '0;
                idx         <= '0;
                stop_bad    <= 1'b0;
                second_stop <= 1'b0;
                par_bit     <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == CNT_FULL) begin
              cnt        <= '0;
              shreg[idx] <= line;
              idx        <= idx + 1'b1;
              if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == CNT_FULL) begin
              cnt     <= '0;
              par_bit <= line;
              st      <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == CNT_FULL) begin
              cnt      <= '0;
              stop_bad <= stop_bad | ~line;
              if (stop2 && !second_stop) begin
                second_stop <= 1'b1;
              end else begin
                done <= 1'b1;
                st   <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign frame.data = shreg;
  assign frame.fe   = stop_bad;
  assign frame.pe   = par_en & ((^shreg ^ par_bit) != par_odd);
endmodule

// File: rtl/uart_err_rx_buf.sv
module uart_err_rx_buf
  import uart_err_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t wr,
  input  logic      pop,
  output rx_entry_t head,
  output logic      not_empty,
  output logic      full,
  output logic      head_load,
  output rx_entry_t head_next
);
  rx_entry_t   slot0, slot1;
  logic [1:0]  count;
  logic        do_pop, do_push;

  assign not_empty = (count != 2'd0);
  assign full      = (count == 2'd2);
  assign do_pop    = pop & not_empty;
  assign do_push   = push & (!full | do_pop);
  assign head      = slot0;

  always_comb begin
    head_load = 1'b0;
    head_next = slot0;
    if (do_pop) begin
      if (count == 2'd2) begin
        head_load = 1'b1;
        head_next = slot1;
      end else if (do_push) begin
        head_load = 1'b1;
        head_next = wr;
      end
    end else if (do_push && count == 2'd0) begin
      head_load = 1'b1;
      head_next = wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0;
      slot1 <= '0;
      count <= '0;
    end else begin
      if (head_load) slot0 <= head_next;
      if (do_push && ((count == 2'd1 && !do_pop) || (count == 2'd2 && do_pop)))
        slot1 <= wr;
      count <= count + {1'b0, do_push} - {1'b0, do_pop};
    end
  end
endmodule

// File: rtl/uart_err_rx_flags.sv
module uart_err_rx_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  input  logic [NFLAG-1:0] en,
  output logic [NFLAG-1:0] flag,
  output logic             irq
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end

  assign irq = |(flag & en);
endmodule

// File: rtl/uart_err_rx.sv
module uart_err_rx
  import uart_err_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       cfg_len8,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       fe_flag,
  output logic       pe_flag,
  output logic       oe_flag,
  input  logic       clr_fe,
  input  logic       clr_pe,
  input  logic       clr_oe,
  input  logic       ie_fe,
  input  logic       ie_pe,
  input  logic       ie_oe,
  output logic       irq
);
  logic      line_s;
  logic      fr_done;
  rx_entry_t fr_entry;
  rx_entry_t head, head_next;
  logic      full, head_load, take, overrun;
  logic [2:0] flag_set, flag_q;

  uart_err_rx_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(line_s)
  );

  uart_err_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
    .len8(cfg_len8), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .stop2(cfg_stop2), .done(fr_done), .frame(fr_entry)
  );

  assign take = rx_valid & rx_ready;

  uart_err_rx_buf u_buf (
    .clk(clk), .rst_n(rst_n), .push(fr_done), .wr(fr_entry), .pop(take),
    .head(head), .not_empty(rx_valid), .full(full),
    .head_load(head_load), .head_next(head_next)
  );

  assign overrun  = fr_done & full & ~take;
  assign flag_set = {overrun, head_load & head_next.pe, head_load & head_next.fe};

  uart_err_rx_flags #(.NFLAG(3)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set),
    .clr({clr_oe, clr_pe, clr_fe}), .en({ie_oe, ie_pe, ie_fe}),
    .flag(flag_q), .irq(irq)
  );

  assign rx_data = head.data;
  assign fe_flag = flag_q[0];
  assign pe_flag = flag_q[1];
  assign oe_flag = flag_q[2];
endmodule

// File: rtl/uart_err_rx_chk.sv
module uart_err_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       fe_flag,
  input logic       oe_flag,
  input logic       clr_fe,
  input logic       clr_oe
);
  // R11
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  // R6
  fe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_flag) |-> rx_valid);

  // R9
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_flag) |-> $past(clr_fe));

  // R9
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_flag) |-> $past(clr_oe));

  // R8
  oe_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_flag) |-> rx_valid);
endmodule

bind uart_err_rx uart_err_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .fe_flag(fe_flag), .oe_flag(oe_flag),
  .clr_fe(clr_fe), .clr_oe(clr_oe)
);

// File: tb/uart_err_rx_bench.sv
module uart_err_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic rx_ready = 1'b0;
  logic clr_fe = 1'b0, clr_pe = 1'b0, clr_oe = 1'b0;
  logic ie_fe = 1'b0, ie_pe = 1'b0, ie_oe = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, fe_flag, pe_flag, oe_flag, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_err_rx u_uart_err_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rxd(rxd),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .fe_flag(fe_flag), .pe_flag(pe_flag),
    .oe_flag(oe_flag), .clr_fe(clr_fe), .clr_pe(clr_pe), .clr_oe(clr_oe),
    .ie_fe(ie_fe), .ie_pe(ie_pe), .ie_oe(ie_oe), .irq(irq)
  );

  // {len8, par_en, odd, stop2, spoil_parity, spoil_stop, data}
  localparam logic [13:0] VEC [8] = '{
    {6'b100000, 8'hA5},
    {6'b000000, 8'hD3},
    {6'b110000, 8'h3C},
    {6'b111000, 8'h3C},
    {6'b101100, 8'h81},
    {6'b110010, 8'h5E},
    {6'b100001, 8'h77},
    {6'b011111, 8'h2B}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic v);
    rxd = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic bad_par, logic bad_stop);
    logic [7:0] m;
    m = cfg_len8 ? d : {1'b0, d[6:0]};
    @(negedge clk);
    bit_out(1'b0);
    for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) bit_out(m[i]);
    if (cfg_par_en) bit_out((^m) ^ cfg_par_odd ^ bad_par);
    bit_out(~bad_stop);
    if (cfg_stop2) bit_out(1'b1);
    rxd = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic take();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic clear_all();
    clr_fe = 1'b1; clr_pe = 1'b1; clr_oe = 1'b1;
    @(negedge clk);
    clr_fe = 1'b0; clr_pe = 1'b0; clr_oe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset valid", rx_valid, 0);
    chk("R9 reset flags", {fe_flag, pe_flag, oe_flag}, 0);
    chk("R10 reset irq", irq, 0);

    // Table walk: R1 R3 R4 R5
    foreach (VEC[k]) begin
      logic [7:0] d;
      logic e_fe, e_pe;
      {cfg_len8, cfg_par_en, cfg_par_odd, cfg_stop2} = VEC[k][13:10];
      d = VEC[k][7:0];
      send(d, VEC[k][9], VEC[k][8]);
      e_fe = VEC[k][8];
      e_pe = VEC[k][12] & VEC[k][9];
      chk("R5 stored", rx_valid, 1);
      chk("R1 data", rx_data, cfg_len8 ? d : {1'b0, d[6:0]});
      chk("R4 framing", fe_flag, e_fe);
      chk("R3 parity", pe_flag, e_pe);
      take();
      chk("R11 drained", rx_valid, 0);
      clear_all();
      chk("R9 cleared", {fe_flag, pe_flag}, 0);
    end

    // R6: flag rises with the erroneous byte when buffer empty; R10 irq
    {cfg_len8, cfg_par_en, cfg_par_odd, cfg_stop2} = 4'b1100;
    ie_pe = 1'b1;
    send(8'h11, 1'b1, 1'b0);
    chk("R6 pe with data", {rx_valid, pe_flag}, 2'b11);
    chk("R10 irq pe", irq, 1);
    ie_pe = 1'b0;
    @(negedge clk);
    chk("R10 irq masked", irq, 0);
    take();
    chk("R9 pe holds after take", pe_flag, 1);
    clear_all();

    // R7: deferred framing flag behind a good byte
    cfg_par_en = 1'b0;
    send(8'h4A, 1'b0, 1'b0);
    send(8'hB6, 1'b0, 1'b1);
    chk("R7 flag deferred", fe_flag, 0);
    chk("R11 head first", rx_data, 8'h4A);
    take();
    chk("R7 head second", rx_data, 8'hB6);
    chk("R7 flag at head", fe_flag, 1);
    take();
    chk("R9 fe sticky", fe_flag, 1);
    clr_fe = 1'b1;
    @(negedge clk);
    clr_fe = 1'b0;
    chk("R9 fe cleared", fe_flag, 0);

    // R8: overrun drops the third frame
    ie_oe = 1'b1;
    send(8'h01, 1'b0, 1'b0);
    send(8'h02, 1'b0, 1'b0);
    chk("R8 no early overrun", oe_flag, 0);
    send(8'h03, 1'b0, 1'b0);
    chk("R8 overrun", oe_flag, 1);
    chk("R10 irq oe", irq, 1);
    chk("R8 head kept", rx_data, 8'h01);
    take();
    chk("R8 second kept", rx_data, 8'h02);
    take();
    chk("R8 third dropped", rx_valid, 0);
    clear_all();
    chk("R9 oe cleared", {oe_flag, irq}, 2'b00);
    ie_oe = 1'b0;

    // R2: short low pulse ignored
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk("R2 glitch ignored", rx_valid, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule